// File: doc/BRIEF.md
# Integer ALU with Condition-Code Register

This block is a 32-bit integer arithmetic unit that pairs each result with a four-bit condition-code set: negative, zero, overflow and carry. It accepts two source operands, an operation code and a request to update the codes. It returns the result and the candidate codes in the same cycle. The codes are committed to a register on the next rising clock edge, but only when an update is requested. The unit supports add, subtract, tagged add, tagged subtract, and unsigned and signed multiply, which keeps the low half of the product.

Tagged forms compute the same value as their plain counterparts. They also raise overflow when either operand has a nonzero two-bit tag in its least significant bits. Multiply always clears overflow and carry.

A side port loads the code register from the low nibble of a 32-bit status word. A second port presents the codes in that same word layout, so a test environment can seed the codes before an operation and inspect them afterwards.

Top module: `alu_cc_unit`

## Requirements
- R1: Operation codes are 0 add, 1 subtract, 2 tagged add, 3 tagged subtract, 4 unsigned multiply, 5 signed multiply. `result_o` is a+b, a-b, a+b, a-b, or the low 32 bits of the unsigned or two's-complement product, all taken modulo 2^32.
- R2: For every operation, `cc_next_o[3]` (N) equals bit 31 of `result_o`, and `cc_next_o[2]` (Z) is 1 exactly when `result_o` is all zeros.
- R3: For add, V = (a31&b31&~r31)|(~a31&~b31&r31) in `cc_next_o[1]`, and C = (a31&b31)|(~r31&(a31|b31)) in `cc_next_o[0]`. C is the unsigned carry out.
- R4: For subtract, V = (a31&~b31&~r31)|(~a31&b31&r31), and C = (~a31&b31)|(r31&(~a31|b31)). C is set exactly when a < b unsigned (borrow).
- R5: Tagged add and tagged subtract give the same result, N, Z and C as plain add and subtract. Their V is the plain V ORed with (a[1:0]!=0)|(b[1:0]!=0).
- R6: For both multiplies, V and C in `cc_next_o` are 0.
- R7: On a rising clock edge with `valid_i`=1, `cc_en_i`=1 and a legal operation code, the code register (`cc_o`) takes `cc_next_o`. In every other case, with no load, it keeps its value.
- R8: An active-low asynchronous `rst_ni` clears the code register to 0 immediately.
- R9: With `cc_load_i`=1, the code register takes `cc_load_data_i[3:0]` on the next rising edge, and bits 31:4 have no effect. A load wins over an update in the same cycle.
- R10: `cc_word_o` carries the codes as {N,Z,V,C} in bits 3 down to 0, and bits 31:4 read as zero.
- R11: Codes 6 and 7 are reserved. For them, `result_o` is 0, and the code register is never written by an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code |
| cc_en_i | input | 1 | Commit codes of this operation |
| a_i | input | 32 | First source operand |
| b_i | input | 32 | Second source operand |
| result_o | output | 32 | Combinational result |
| cc_next_o | output | 4 | Combinational candidate codes {N,Z,V,C} |
| cc_load_i | input | 1 | Load the code register from the status word |
| cc_load_data_i | input | 32 | Status word; bits 3:0 are used |
| cc_o | output | 4 | Code register {N,Z,V,C} |
| cc_word_o | output | 32 | Code register in status-word layout |

## Verification
Add is driven with operands that separate the flags from one another:
- 0x7fffffff+1 gives signed overflow with no carry.
- 0xffffffff+1 gives carry and zero with no overflow.
- 0x80000000+0x80000000 raises V, C and Z together.

Subtract is tried with a < b, with equal operands, and with 0x80000000-1, which separates the borrow from signed overflow. Tagged operations use aligned and misaligned operands with otherwise identical values, so the extra overflow term is isolated. Multiplies use all-ones operands and mixed-sign operands, which separates signed and unsigned interpretation while the low word stays common. A long run of mixed random operations is then compared against a behavioural 33- and 64-bit model on every clock.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  localparam int unsigned OP_W = 3;
  localparam int unsigned CC_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_TADD = 3'd2,
    OP_TSUB = 3'd3,
    OP_UMUL = 3'd4,
    OP_SMUL = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

  function automatic logic op_is_legal(alu_op_e op);
    return (op != OP_RSV6) && (op != OP_RSV7);
  endfunction

  function automatic logic op_is_mul(alu_op_e op);
    return (op == OP_UMUL) || (op == OP_SMUL);
  endfunction

  function automatic logic op_is_sub(alu_op_e op);
    return (op == OP_SUB) || (op == OP_TSUB);
  endfunction

  function automatic logic op_is_tag(alu_op_e op);
    return (op == OP_TADD) || (op == OP_TSUB);
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned TAG_W = 2
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic             tag_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             v_o,
  output logic             c_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   raw;
  logic             a_s, b_s, r_s;
  logic             v_add, v_sub, c_add, c_sub;
  logic             tag_bad;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign raw   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o = raw[MSB:0];

  assign a_s = a_i[MSB];
  assign b_s = b_i[MSB];
  assign r_s = sum_o[MSB];

  // sign-bit flag equations, kept separate from the adder carry chain
  assign v_add = (a_s & b_s & ~r_s) | (~a_s & ~b_s & r_s);
  assign c_add = (a_s & b_s) | (~r_s & (a_s | b_s));
  assign v_sub = (a_s & ~b_s & ~r_s) | (~a_s & b_s & r_s);
  assign c_sub = (~a_s & b_s) | (r_s & (~a_s | b_s));

  generate
    if (TAG_W > 0) begin : g_tag
      assign tag_bad = (|a_i[TAG_W-1:0]) | (|b_i[TAG_W-1:0]);
    end else begin : g_notag
      assign tag_bad = 1'b0;
    end
  endgenerate

  assign v_o = (sub_i ? v_sub : v_add) | (tag_i & tag_bad);
  assign c_o = sub_i ? c_sub : c_add;
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
  parameter int unsigned WIDTH     = 32,
  parameter bit          FULL_PROD = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             signed_i,
  output logic [WIDTH-1:0] prod_o
);
  localparam int unsigned PW = 2 * WIDTH;

  generate
    if (FULL_PROD) begin : g_full
      logic [PW-1:0] ext_a, ext_b, prod;
      assign ext_a  = {{WIDTH{signed_i & a_i[WIDTH-1]}}, a_i};
      assign ext_b  = {{WIDTH{signed_i & b_i[WIDTH-1]}}, b_i};
      assign prod   = ext_a * ext_b;
      assign prod_o = prod[WIDTH-1:0];
    end else begin : g_low
      // low half is sign-independent
      logic unused_sign;
      assign unused_sign = signed_i;
      assign prod_o      = a_i * b_i;
    end
  endgenerate
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_cc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             arith_i,
  input  logic             v_i,
  input  logic             c_i,
  output cc_t              cc_o
);
  always_comb begin
    cc_o.n = res_i[WIDTH-1];
    cc_o.z = (res_i == '0);
    cc_o.v = arith_i & v_i;
    cc_o.c = arith_i & c_i;
  end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned TAG_W     = 2,
  parameter bit          FULL_PROD = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic             cc_en_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic [3:0]       cc_next_o,
  input  logic             cc_load_i,
  input  logic [31:0]      cc_load_data_i,
  output logic [3:0]       cc_o,
  output logic [31:0]      cc_word_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] sum, prod;
  logic             as_v, as_c;
  logic             legal, upd;
  cc_t              cc_next, cc_q;

  assign op    = alu_op_e'(op_i);
  assign legal = op_is_legal(op);
  assign upd   = valid_i & cc_en_i & legal;

  alu_addsub #(.WIDTH(WIDTH), .TAG_W(TAG_W)) i_addsub (
    .a_i  (a_i),
    .b_i  (b_i),
    .sub_i(op_is_sub(op)),
    .tag_i(op_is_tag(op)),
    .sum_o(sum),
    .v_o  (as_v),
    .c_o  (as_c)
  );

  alu_mul #(.WIDTH(WIDTH), .FULL_PROD(FULL_PROD)) i_mul (
    .a_i     (a_i),
    .b_i     (b_i),
    .signed_i(op == OP_SMUL),
    .prod_o  (prod)
  );

  always_comb begin
    if (!legal)               result_o = '0;
    else if (op_is_mul(op))   result_o = prod;
    else                      result_o = sum;
  end

  alu_flags #(.WIDTH(WIDTH)) i_flags (
    .res_i  (result_o),
    .arith_i(legal & ~op_is_mul(op)),
    .v_i    (as_v),
    .c_i    (as_c),
    .cc_o   (cc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cc_q <= '0;
    else if (cc_load_i) cc_q <= cc_t'(cc_load_data_i[3:0]);
    else if (upd)       cc_q <= cc_next;
  end

  assign cc_next_o = cc_next;
  assign cc_o      = cc_q;
  assign cc_word_o = {28'd0, cc_q};

  // R7: codes only move on a request
  p_cc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cc_load_i && !upd) |=> $stable(cc_o));
  // R7: committed value is the candidate seen at the edge
  p_cc_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cc_load_i && upd) |=> (cc_o == $past(cc_next_o)));
  // R9: load takes low nibble and wins over update
  p_cc_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_load_i |=> (cc_o == $past(cc_load_data_i[3:0])));
  // R6: multiply never reports overflow or carry
  p_mul_vc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_is_mul(op)) |-> (cc_next_o[1:0] == 2'b00));
  // R5: misaligned tagged operand raises overflow
  p_tag_ovf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_is_tag(op) && ((a_i[1:0] != 2'b00) || (b_i[1:0] != 2'b00)))
      |-> cc_next_o[1]);
  // R11: reserved codes yield zero
  p_rsv_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !legal) |-> (result_o == '0));
  // R10: upper status bits read zero
  p_word_upper_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_word_o[31:4] == 28'd0);
endmodule

// File: tb/test_alu_cc_unit.sv
`timescale 1ns/1ps
module test_alu_cc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, cc_en = 1'b0, ld = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] a = '0, b = '0, ld_data = '0;
  logic [31:0] result, cc_word;
  logic [3:0]  cc_next, cc;
  logic [3:0]  cc_m = 4'h0;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  alu_cc_unit i_alu_cc_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .cc_en_i(cc_en),
    .a_i(a), .b_i(b), .result_o(result), .cc_next_o(cc_next),
    .cc_load_i(ld), .cc_load_data_i(ld_data), .cc_o(cc), .cc_word_o(cc_word)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: wide integer arithmetic
  task automatic model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                       output logic [31:0] r, output logic [3:0] f);
    longint sx, sy, s;
    logic [32:0] u;
    logic [63:0] p;
    logic n, z, v, c;
    sx = longint'($signed(x)); sy = longint'($signed(y));
    v = 1'b0; c = 1'b0;
    case (o)
      3'd0, 3'd2: begin u = {1'b0, x} + {1'b0, y}; r = u[31:0]; c = u[32];
                        s = sx + sy; v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      3'd1, 3'd3: begin r = x - y; c = (x < y);
                        s = sx - sy; v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      3'd4: begin p = {32'd0, x} * {32'd0, y}; r = p[31:0]; end
      3'd5: begin p = 64'(sx * sy); r = p[31:0]; end
      default: r = 32'd0;
    endcase
    if ((o == 3'd2 || o == 3'd3) && (x[1:0] != 0 || y[1:0] != 0)) v = 1'b1;
    n = r[31]; z = (r == 0);
    f = {n, z, v, c};
  endtask

  task automatic run(string req, input logic [2:0] o, input logic vl, input logic en,
                     input logic [31:0] x, input logic [31:0] y,
                     input logic l = 1'b0, input logic [31:0] ldv = 32'd0);
    logic [31:0] er;
    logic [3:0]  ef;
    @(negedge clk);
    op = o; valid = vl; cc_en = en; a = x; b = y; ld = l; ld_data = ldv;
    #1;
    model(o, x, y, er, ef);
    chk({req, " result"}, result, er);
    chk({req, " cc_next"}, {28'd0, cc_next}, {28'd0, ef});
    if (l) cc_m = ldv[3:0];
    else if (vl && en && o < 3'd6) cc_m = ef;
    @(posedge clk); #1;
    chk({req, " cc"}, {28'd0, cc}, {28'd0, cc_m});
    chk({req, " word"}, cc_word, {28'd0, cc_m});
    valid = 1'b0; ld = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R8 reset", {28'd0, cc}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 add corners
    run("R3 zero", 3'd0, 1, 1, 32'd0, 32'd0);
    run("R3 ovf", 3'd0, 1, 1, 32'h7fffffff, 32'd1);
    run("R3 carry", 3'd0, 1, 1, 32'hffffffff, 32'd1);
    run("R3 vcz", 3'd0, 1, 1, 32'h80000000, 32'h80000000);
    run("R1 add", 3'd0, 1, 1, 32'h12345678, 32'h0fedcba8);
    // R4 subtract corners
    run("R4 plain", 3'd1, 1, 1, 32'd5, 32'd3);
    run("R4 borrow", 3'd1, 1, 1, 32'd3, 32'd5);
    run("R4 equal", 3'd1, 1, 1, 32'hdeadbeef, 32'hdeadbeef);
    run("R4 ovf", 3'd1, 1, 1, 32'h80000000, 32'd1);
    // R5 tagged
    run("R5 aligned", 3'd2, 1, 1, 32'h00000104, 32'h00000008);
    run("R5 tag_a", 3'd2, 1, 1, 32'h00000105, 32'h00000008);
    run("R5 tsub_b", 3'd3, 1, 1, 32'h00000010, 32'h00000022);
    run("R5 tsub_al", 3'd3, 1, 1, 32'h00000010, 32'h00000020);
    // R6 multiply
    run("R6 umul", 3'd4, 1, 1, 32'hffffffff, 32'hffffffff);
    run("R6 smul", 3'd5, 1, 1, 32'hfffffffd, 32'd7);
    run("R6 mulz", 3'd4, 1, 1, 32'h00010000, 32'h00010000);
    run("R2 smulneg", 3'd5, 1, 1, 32'h80000000, 32'd1);
    // R7 hold when no update requested
    run("R9 seed", 3'd0, 0, 0, 0, 0, 1'b1, 32'hfffffff5);
    run("R7 en_off", 3'd0, 1, 0, 32'd0, 32'd0);
    run("R7 vld_off", 3'd1, 0, 1, 32'd3, 32'd5);
    // R11 reserved
    run("R11 rsv6", 3'd6, 1, 1, 32'h1, 32'h2);
    run("R11 rsv7", 3'd7, 1, 1, 32'hffffffff, 32'h1);
    // R9 load priority over update
    run("R9 prio", 3'd0, 1, 1, 32'hffffffff, 32'd1, 1'b1, 32'habcdef06);
    run("R10 pack", 3'd0, 0, 0, 0, 0, 1'b1, 32'h00000008);
    // R8 asynchronous clear mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    cc_m = 4'h0;
    chk("R8 async", {28'd0, cc}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // R1 R2 mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      logic [2:0]  o;
      x = $urandom; y = $urandom; o = 3'($urandom % 8);
      if (i % 5 == 0) y = x;
      run("R1 R2 rand", o, 1'($urandom), 1'($urandom), x, y,
          (i % 17 == 0), $urandom);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule